// File: doc/BRIEF.md
# Cascadable LCD Column Data Loader

This block gathers one display line of column data for a single segment driver in a chain of such drivers. Data arrives on a shift strobe, either a full byte per strobe or a nibble per strobe. The block packs it into bytes and places each byte into a 240-bit staging latch. It accepts data only while it is selected. It becomes selected when the upstream enable is seen after a line pulse. Once the thirtieth byte has landed, it raises an enable for the next chip in the chain and stops accepting data.

When the line pulse goes high, the loading logic returns to its waiting state. On the falling edge of the line pulse, the whole staging latch is copied in one cycle into the line register that feeds the output stage. Bytes fill the latch in ascending or descending slot order, as set by a direction input. Internally the byte pointer is kept as a 16-bit group index plus a byte-within-group index.

Top module: `cascade_col_loader`

## Requirements
- R1: After reset, `enOut` is 0 and `lineData` is all zeros.
- R2: With `wideMode`=1, every `shiftEn` cycle accepted while selected writes `dataIn[7:0]` as one byte.
- R3: With `wideMode`=0, two accepted `shiftEn` cycles form one byte: the first `dataIn[3:0]` becomes bits [3:0] and the second `dataIn[3:0]` becomes bits [7:4]. `dataIn[7:4]` is ignored in this mode.
- R4: With `dirRev`=0, the k-th byte of a line (k from 0) goes to `lineData[8k+7:8k]`. With `dirRev`=1 it goes to `lineData[8(29-k)+7:8(29-k)]`.
- R5: The block is selected from the cycle after a clock edge that sees `enIn`=1 while `linePulse`=0. Shift data presented before that has no effect.
- R6: `enOut` rises in the cycle after the clock edge that writes byte 29 (the 240th bit), and stays 1 until a line pulse. Data presented while it is 1 is not written.
- R7: While `linePulse` is 1, the byte pointer, the pending nibble and the selection are cleared, and `enOut` reads 0 from the next cycle.
- R8: `lineData` takes the latch contents at the clock edge where `linePulse` is sampled 0 after being 1. At all other times it is unchanged.
- R9: A nibble that is still waiting for its partner when a line pulse arrives is discarded.
- R10: A partial line writes only its own bytes. The remaining latch bytes keep their earlier values, and `enOut` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wideMode | input | 1 | 1: byte per strobe, 0: nibble per strobe |
| dirRev | input | 1 | 1: fill latch from the top slot downward |
| enIn | input | 1 | Enable from the previous chip in the chain |
| linePulse | input | 1 | Line pulse; high resets loading, falling edge transfers |
| shiftEn | input | 1 | Data strobe, one per shift clock |
| dataIn | input | 8 | Shift data (low nibble only in nibble mode) |
| enOut | output | 1 | Enable to the next chip in the chain |
| lineData | output | 240 | Line register contents |

## Verification
A wrong pointer or direction shows up only at the next line transfer, as bytes that are misplaced or repeated in `lineData`. The bench therefore compares the full 240-bit value after every line against a model it computes itself. A wrong selection or nibble phase shifts every later byte by one slot, which is visible in the same transfer. A fault in the count that decides completion shows directly on `enOut`, one cycle after the 29th or 30th byte. The sweep covers both widths and both directions, plus lines that start unselected, lines that overrun, lines cut short, and lines with a stray nibble.

// File: rtl/col_loader_pkg.sv
package col_loader_pkg;

  // Strobes from the sequencer into the datapath.
  typedef struct packed {
    logic capNib;  // hold the low nibble of a byte being assembled
    logic wrByte;  // place the assembled byte into the staging latch
    logic xfer;    // copy staging latch into the line register
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_LOAD = 2'd1,
    ST_FULL = 2'd2
  } loadState_t;

endpackage

// File: rtl/col_loader_ctrl.sv
module col_loader_ctrl
  import col_loader_pkg::*;
#(
  parameter int GROUPS = 15,
  parameter int BPG    = 2,
  parameter int GRP_W  = 4,
  parameter int SUB_W  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             linePulse,
  input  logic             enIn,
  input  logic             shiftEn,
  input  logic             wideMode,
  output dpStrobe_t        strb,
  output logic [GRP_W-1:0] grpPtr,
  output logic [SUB_W-1:0] subPtr,
  output logic             enOut
);

  loadState_t state;
  logic       lpQ;
  logic       halfFull;
  logic       accept;
  logic       lastByte;
  logic       lastSub;

  always_comb begin
    accept      = (state == ST_LOAD) && shiftEn && !linePulse;
    strb.capNib = accept && !wideMode && !halfFull;
    strb.wrByte = accept && (wideMode || halfFull);
    strb.xfer   = lpQ && !linePulse;
    lastSub     = (subPtr == SUB_W'(BPG - 1));
    lastByte    = lastSub && (grpPtr == GRP_W'(GROUPS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_WAIT;
      lpQ      <= 1'b0;
      halfFull <= 1'b0;
      grpPtr   <= '0;
      subPtr   <= '0;
      enOut    <= 1'b0;
    end else begin
      lpQ <= linePulse;
      if (linePulse) begin
        state    <= ST_WAIT;
        halfFull <= 1'b0;
        grpPtr   <= '0;
        subPtr   <= '0;
        enOut    <= 1'b0;
      end else begin
        unique case (state)
          ST_WAIT: if (enIn) state <= ST_LOAD;
          ST_LOAD: begin
            if (strb.capNib) halfFull <= 1'b1;
            if (strb.wrByte) begin
              halfFull <= 1'b0;
              if (lastByte) begin
                state <= ST_FULL;
                enOut <= 1'b1;
              end else if (lastSub) begin
                subPtr <= '0;
                grpPtr <= grpPtr + 1'b1;
              end else begin
                subPtr <= subPtr + 1'b1;
              end
            end
          end
          ST_FULL: state <= ST_FULL;
          default: state <= ST_WAIT;
        endcase
      end
    end
  end

endmodule

// File: rtl/col_loader_dp.sv
module col_loader_dp
  import col_loader_pkg::*;
#(
  parameter int LATCH_BITS = 240,
  parameter int BUS_W      = 8,
  parameter int BPG        = 2,
  parameter int GROUPS     = 15,
  parameter int GRP_W      = 4,
  parameter int SUB_W      = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic [GRP_W-1:0]      grpPtr,
  input  logic [SUB_W-1:0]      subPtr,
  input  logic                  dirRev,
  input  logic                  wideMode,
  input  logic [BUS_W-1:0]      dataIn,
  output logic [LATCH_BITS-1:0] lineData
);

  localparam int NIB_W = BUS_W / 2;
  localparam int SLOTS = GROUPS * BPG;

  logic [NIB_W-1:0]      nibLo;
  logic [BUS_W-1:0]      busByte;
  logic [GRP_W-1:0]      dirGrp;
  logic [SUB_W-1:0]      dirSub;
  logic [GROUPS-1:0]     grpOneHot;
  logic [BPG-1:0]        subOneHot;
  logic [LATCH_BITS-1:0] stageLatch;

  always_comb begin
    busByte = wideMode ? dataIn : {dataIn[NIB_W-1:0], nibLo};
    dirGrp  = dirRev ? (GRP_W'(GROUPS - 1) - grpPtr) : grpPtr;
    dirSub  = dirRev ? (SUB_W'(BPG - 1) - subPtr) : subPtr;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grpSel
    assign grpOneHot[g] = (dirGrp == GRP_W'(g));
  end
  for (genvar s = 0; s < BPG; s++) begin : g_subSel
    assign subOneHot[s] = (dirSub == SUB_W'(s));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nibLo <= '0;
    else if (strb.capNib) nibLo <= dataIn[NIB_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageLatch <= '0;
    end else if (strb.wrByte) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (grpOneHot[i / BPG] && subOneHot[i % BPG])
          stageLatch[i*BUS_W +: BUS_W] <= busByte;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineData <= '0;
    else if (strb.xfer) lineData <= stageLatch;
  end

endmodule

// File: rtl/cascade_col_loader.sv
module cascade_col_loader
  import col_loader_pkg::*;
#(
  parameter int LATCH_BITS = 240,
  parameter int BUS_W      = 8,
  parameter int GROUP_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wideMode,
  input  logic                  dirRev,
  input  logic                  enIn,
  input  logic                  linePulse,
  input  logic                  shiftEn,
  input  logic [BUS_W-1:0]      dataIn,
  output logic                  enOut,
  output logic [LATCH_BITS-1:0] lineData
);

  localparam int BPG    = GROUP_BITS / BUS_W;
  localparam int GROUPS = LATCH_BITS / GROUP_BITS;
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int SUB_W  = (BPG > 1) ? $clog2(BPG) : 1;

  dpStrobe_t        ctl;
  logic [GRP_W-1:0] grpPtr;
  logic [SUB_W-1:0] subPtr;

  col_loader_ctrl #(
    .GROUPS(GROUPS), .BPG(BPG), .GRP_W(GRP_W), .SUB_W(SUB_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .linePulse(linePulse), .enIn(enIn),
    .shiftEn(shiftEn), .wideMode(wideMode), .strb(ctl),
    .grpPtr(grpPtr), .subPtr(subPtr), .enOut(enOut)
  );

  col_loader_dp #(
    .LATCH_BITS(LATCH_BITS), .BUS_W(BUS_W), .BPG(BPG), .GROUPS(GROUPS),
    .GRP_W(GRP_W), .SUB_W(SUB_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(ctl), .grpPtr(grpPtr), .subPtr(subPtr),
    .dirRev(dirRev), .wideMode(wideMode), .dataIn(dataIn),
    .lineData(lineData)
  );

endmodule

// File: rtl/col_loader_chk.sv
module col_loader_chk #(
  parameter int LATCH_BITS = 240
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  linePulse,
  input logic                  enOut,
  input logic                  wrByte,
  input logic                  xfer,
  input logic [LATCH_BITS-1:0] lineData
);

  // R7: a line pulse clears the downstream enable
  p_en_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    linePulse |=> !enOut);

  // R6: the enable holds until a line pulse
  p_en_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enOut && !linePulse) |=> enOut);

  // R6: no writes once the line is complete
  p_no_write_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    enOut |-> !wrByte);

  // R6: the enable only rises right after a byte write
  p_en_after_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enOut) |-> $past(wrByte));

  // R8: the line register changes only on a transfer
  p_line_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !xfer |=> $stable(lineData));

  // R8: a transfer happens only after the pulse was high
  p_xfer_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    xfer |-> ($past(linePulse) && !linePulse));

endmodule

bind cascade_col_loader col_loader_chk #(.LATCH_BITS(LATCH_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .linePulse(linePulse), .enOut(enOut),
  .wrByte(ctl.wrByte), .xfer(ctl.xfer), .lineData(lineData)
);

// File: tb/sim_cascade_col_loader.sv
`timescale 1ns/1ps
module sim_cascade_col_loader;

  localparam int NBYTES = 30;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wideMode = 1'b1;
  logic         dirRev = 1'b0;
  logic         enIn = 1'b0;
  logic         linePulse = 1'b0;
  logic         shiftEn = 1'b0;
  logic [7:0]   dataIn = '0;
  logic         enOut;
  logic [239:0] lineData;

  logic [239:0] expLatch = '0;
  logic [239:0] prevLine = '0;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cascade_col_loader u0 (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .dirRev(dirRev),
    .enIn(enIn), .linePulse(linePulse), .shiftEn(shiftEn),
    .dataIn(dataIn), .enOut(enOut), .lineData(lineData)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [239:0] act, input logic [239:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] patByte(int k, int seed);
    return 8'((k * 37 + seed * 11 + 3) & 255);
  endfunction

  task automatic shiftOne(input logic [7:0] d);
    shiftEn = 1'b1;
    dataIn  = d;
    @(negedge clk);
    shiftEn = 1'b0;
    dataIn  = 8'hxx ^ 8'hxx;
  endtask

  task automatic sendByte(input logic [7:0] b);
    if (wideMode) shiftOne(b);
    else begin
      shiftOne({4'hA, b[3:0]});  // upper bits must be ignored (R3)
      shiftOne({4'h5, b[7:4]});
    end
  endtask

  task automatic pulseLine();
    linePulse = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(enOut == 1'b0, "R7 enOut cleared by line pulse", 240'(enOut), 240'(0));
    linePulse = 1'b0;
    @(negedge clk);
    check(lineData == expLatch, "R8 line transfer R2 R3 R4", lineData, expLatch);
    prevLine = lineData;
  endtask

  task automatic feedLine(input int n, input int seed, input bit doEnable);
    if (doEnable) begin
      enIn = 1'b1;
      @(negedge clk);
      enIn = 1'b0;
    end
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = patByte(k, seed);
      sendByte(b);
      if (k < NBYTES) begin
        int slot;
        slot = dirRev ? (NBYTES - 1 - k) : k;
        expLatch[slot*8 +: 8] = b;
      end
      if (k == NBYTES - 2)
        check(enOut == 1'b0, "R6 enOut low before last byte", 240'(enOut), 240'(0));
      if (k >= NBYTES - 1)
        check(enOut == 1'b1, "R6 enOut high after last byte", 240'(enOut), 240'(1));
      if (k == 5)
        check(lineData == prevLine, "R8 line stable while loading", lineData, prevLine);
    end
  endtask

  initial begin
    #(20_000_000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(enOut == 1'b0, "R1 reset enOut", 240'(enOut), 240'(0));
    check(lineData == '0, "R1 reset lineData", lineData, '0);
    rstN = 1'b1;
    @(negedge clk);

    // Sweep both widths and both directions (R2 R3 R4)
    for (int w = 0; w < 2; w++) begin
      for (int d = 0; d < 2; d++) begin
        wideMode = w[0];
        dirRev   = d[0];
        pulseLine();
        feedLine(NBYTES, w * 2 + d + 1, 1'b1);
        pulseLine();
      end
    end

    // R5: data before selection ignored
    for (int w = 0; w < 2; w++) begin
      wideMode = w[0];
      dirRev   = 1'b0;
      for (int k = 0; k < 3; k++) sendByte(8'hEE);
      check(enOut == 1'b0, "R5 unselected stays idle", 240'(enOut), 240'(0));
      feedLine(NBYTES, 7 + w, 1'b1);
      pulseLine();
    end

    // R6: bytes beyond the line are not written
    wideMode = 1'b1;
    dirRev   = 1'b1;
    feedLine(NBYTES + 4, 9, 1'b1);
    pulseLine();

    // R9: stray nibble discarded by line pulse
    wideMode = 1'b0;
    dirRev   = 1'b0;
    enIn = 1'b1;
    @(negedge clk);
    enIn = 1'b0;
    shiftOne(8'h0F);
    pulseLine();
    feedLine(NBYTES, 12, 1'b1);
    pulseLine();

    // R10: partial line keeps older bytes, no downstream enable
    wideMode = 1'b1;
    dirRev   = 1'b0;
    feedLine(12, 13, 1'b1);
    check(enOut == 1'b0, "R10 partial line enOut low", 240'(enOut), 240'(0));
    pulseLine();
    dirRev = 1'b1;
    feedLine(17, 14, 1'b1);
    check(enOut == 1'b0, "R10 partial reversed enOut low", 240'(enOut), 240'(0));
    pulseLine();

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule